// File: doc/BRIEF.md
# Multi-Mode LUT Slice Cell

This cell is one half of a programmable logic slice. A single 16-bit storage array is reused in three ways, chosen by a mode input. It can be a 4-input function generator, where the read address selects one of sixteen configuration bits. It can be a 16x1 memory with independent read and write addresses. It can also be a 16-stage shift register whose output tap is chosen by the read address. The array output drives a carry stage for arithmetic, in which the array output acts as the propagate term.

The array output or the carry-stage sum feeds one output storage element. That element can be an edge-triggered flip-flop or a transparent latch. Its clock polarity and its enable polarity can each be inverted. Its set/reset can act synchronously or asynchronously, and it is loaded with a chosen initial value during reset. The unregistered function output and the registered output are both available at the ports.

Top module: `lut_slice_cell`

## Requirements
- R1: In function mode (cfg_mode 0, or the unused code 3), f_out equals bit rd_addr of the table loaded from cfg_table at reset, and wr_en/din leave that table unchanged.
- R2: In memory mode (cfg_mode 1), a rising clk edge with wr_en=1 stores din at bit wr_addr. With wr_en=0 no bit changes. f_out is bit rd_addr of the array and follows rd_addr without a clock.
- R3: In memory mode, when a write targets the address being read, f_out keeps the old bit before the clock edge and shows din after it.
- R4: In shift mode (cfg_mode 2), a rising clk edge with wr_en=1 moves bit k to bit k+1 and loads din into bit 0. wr_en=0 holds all bits. f_out at rd_addr=N is the din sampled N+1 enabled edges earlier.
- R5: sum_out = f_out XOR cin. cout equals cin when f_out is 1 and equals op_b when f_out is 0.
- R6: f_out is combinational. q_out captures the data input at the active edge: f_out when cfg_dsel=0, sum_out when cfg_dsel=1.
- R7: The active edge is the rising edge of clk when cfg_clk_inv=0 and the falling edge when cfg_clk_inv=1. Capture needs ce XOR cfg_ce_inv = 1, and q_out holds otherwise.
- R8: With cfg_latch=1, q_out follows the data input while clk XOR cfg_clk_inv is 1 and holds while it is 0.
- R9: sr=1 forces q_out to cfg_sr_val. With cfg_sr_async=0 this happens at the active edge, before the enable is considered. With cfg_sr_async=1 it happens at once, without a clock edge.
- R10: rst_n=0 at a rising clk edge loads cfg_table into the array. rst_n=0 at an active edge of the output element loads cfg_init into q_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | 0 function, 1 memory, 2 shift, 3 as function |
| cfg_table | input | 16 | Table loaded into the array at reset |
| cfg_init | input | 1 | Value loaded into the output element at reset |
| cfg_latch | input | 1 | 1 selects latch behaviour of the output element |
| cfg_clk_inv | input | 1 | 1 makes the output element use the falling clock edge |
| cfg_ce_inv | input | 1 | 1 makes ce active low |
| cfg_sr_async | input | 1 | 1 makes sr asynchronous |
| cfg_sr_val | input | 1 | Value forced by sr (1 set, 0 reset) |
| cfg_dsel | input | 1 | Output element data: 0 f_out, 1 sum_out |
| rd_addr | input | 4 | Read address, table index or shift tap |
| wr_addr | input | 4 | Memory write address |
| wr_en | input | 1 | Memory write enable / shift enable |
| din | input | 1 | Memory write data / shift serial input |
| op_b | input | 1 | Operand bit passed to cout when not propagating |
| cin | input | 1 | Carry in |
| ce | input | 1 | Output element enable |
| sr | input | 1 | Output element set/reset |
| f_out | output | 1 | Unregistered array output |
| sum_out | output | 1 | Carry-stage sum |
| cout | output | 1 | Carry out |
| q_out | output | 1 | Registered or latched output |

## Verification
A bad array bit shows on f_out as soon as rd_addr selects it, with no clock. A misrouted write or shift therefore shows in the first read after the edge that caused it. A shift that moves the wrong direction or skips an edge changes every tap past the fault, so checking all sixteen taps after a known serial pattern locates it. Faults in the output element show on q_out at the first active edge, or during the first open phase in latch mode. A clock or enable polarity fault moves a capture by half a cycle or drops it, so q_out is sampled on both sides of each edge. An async set/reset fault is visible before any edge happens.

// File: rtl/lut_slice_pkg.sv
// Package: shared types for the LUT slice cell.
package lut_slice_pkg;
    // Storage array personality selected by cfg_mode.
    typedef enum logic [1:0] {
        MODE_FUNC  = 2'd0,
        MODE_RAM   = 2'd1,
        MODE_SHIFT = 2'd2,
        MODE_SPARE = 2'd3
    } slice_mode_e;
endpackage

// File: rtl/lut_store.sv
// lut_store: 2**ADDR_W x 1 storage array used as a lookup table, as a
// dual-address memory or as a variable-tap shift register.
// Assumes: all writes and shifts happen on the rising clk edge; the read
// is a plain combinational mux; reset copies init_table into the array.
module lut_store
    import lut_slice_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slice_mode_e       mode,
    input  logic [DEPTH-1:0]  init_table,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_en,
    input  logic              din,
    output logic [DEPTH-1:0]  mem_o,
    output logic              rd_o
);
    logic             ram_we;
    logic             shift_en;
    logic [DEPTH-1:0] mem;

    // Decode which write style the current mode allows.
    always_comb begin
        ram_we   = wr_en && (mode == MODE_RAM);
        shift_en = wr_en && (mode == MODE_SHIFT);
    end

    // One storage bit per index: reset load, addressed write or shift.
    for (genvar g = 0; g < DEPTH; g++) begin : g_bit
        logic shift_src;
        if (g == 0) begin : g_head
            assign shift_src = din;
        end else begin : g_body
            assign shift_src = mem[g-1];
        end

        // Update this bit on the rising edge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= init_table[g];
            end else if (ram_we && (wr_addr == ADDR_W'(g))) begin
                mem[g] <= din;
            end else if (shift_en) begin
                mem[g] <= shift_src;
            end
        end
    end

    // Combinational read of the selected bit.
    always_comb begin
        rd_o = mem[rd_addr];
    end

    assign mem_o = mem;
endmodule

// File: rtl/carry_stage.sv
// carry_stage: one bit of a ripple carry chain, with the array output
// acting as the propagate term.
// Assumes: prop is already the XOR of the two operand bits.
module carry_stage (
    input  logic prop,
    input  logic gen_bit,
    input  logic cin,
    output logic sum,
    output logic cout
);
    // Sum bit and the carry mux steered by propagate.
    always_comb begin
        sum  = prop ^ cin;
        cout = prop ? cin : gen_bit;
    end
endmodule

// File: rtl/out_storage.sv
// out_storage: configurable output storage element, either a flip-flop or
// a transparent latch, with clock/enable polarity selection, sync or
// async set/reset and a reset-time initial value.
// Assumes: configuration inputs change only while the element is idle.
module out_storage (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_latch,
    input  logic cfg_clk_inv,
    input  logic cfg_ce_inv,
    input  logic cfg_sr_async,
    input  logic cfg_sr_val,
    input  logic cfg_init,
    input  logic ce,
    input  logic sr,
    input  logic d,
    output logic q
);
    logic eclk;
    logic ce_eff;
    logic asr;
    logic q_ff;
    logic q_lat;

    // Effective clock, enable and asynchronous set/reset.
    always_comb begin
        eclk   = clk ^ cfg_clk_inv;
        ce_eff = ce ^ cfg_ce_inv;
        asr    = sr & cfg_sr_async;
    end

    // Edge-triggered path.
    always_ff @(posedge eclk or posedge asr) begin
        if (asr) begin
            q_ff <= cfg_sr_val;
        end else if (!rst_n) begin
            q_ff <= cfg_init;
        end else if (sr) begin
            q_ff <= cfg_sr_val;
        end else if (ce_eff) begin
            q_ff <= d;
        end
    end

    // Level-sensitive path, transparent while eclk is high.
    always_latch begin
        if (asr) begin
            q_lat <= cfg_sr_val;
        end else if (eclk) begin
            if (!rst_n) begin
                q_lat <= cfg_init;
            end else if (sr) begin
                q_lat <= cfg_sr_val;
            end else if (ce_eff) begin
                q_lat <= d;
            end
        end
    end

    // Select the configured behaviour.
    always_comb begin
        q = cfg_latch ? q_lat : q_ff;
    end
endmodule

// File: rtl/lut_slice_cell.sv
// lut_slice_cell: half of a logic slice. A storage array used as a
// function table, memory or shift register feeds a carry stage and a
// configurable output storage element.
// Assumes: configuration inputs are static while the cell operates.
module lut_slice_cell
    import lut_slice_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [DEPTH-1:0]  cfg_table,
    input  logic              cfg_init,
    input  logic              cfg_latch,
    input  logic              cfg_clk_inv,
    input  logic              cfg_ce_inv,
    input  logic              cfg_sr_async,
    input  logic              cfg_sr_val,
    input  logic              cfg_dsel,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_en,
    input  logic              din,
    input  logic              op_b,
    input  logic              cin,
    input  logic              ce,
    input  logic              sr,
    output logic              f_out,
    output logic              sum_out,
    output logic              cout,
    output logic              q_out
);
    slice_mode_e      mode;
    logic [DEPTH-1:0] mem_bits;
    logic             d_sel;

    // Map the raw mode code onto the enum.
    always_comb begin
        mode = slice_mode_e'(cfg_mode);
    end

    lut_store #(.ADDR_W(ADDR_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .init_table (cfg_table),
        .rd_addr    (rd_addr),
        .wr_addr    (wr_addr),
        .wr_en      (wr_en),
        .din        (din),
        .mem_o      (mem_bits),
        .rd_o       (f_out)
    );

    carry_stage u_carry (
        .prop    (f_out),
        .gen_bit (op_b),
        .cin     (cin),
        .sum     (sum_out),
        .cout    (cout)
    );

    // Pick the data input of the output element.
    always_comb begin
        d_sel = cfg_dsel ? sum_out : f_out;
    end

    out_storage u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_latch    (cfg_latch),
        .cfg_clk_inv  (cfg_clk_inv),
        .cfg_ce_inv   (cfg_ce_inv),
        .cfg_sr_async (cfg_sr_async),
        .cfg_sr_val   (cfg_sr_val),
        .cfg_init     (cfg_init),
        .ce           (ce),
        .sr           (sr),
        .d            (d_sel),
        .q            (q_out)
    );
endmodule

// File: rtl/lut_slice_cell_chk.sv
// lut_slice_cell_chk: temporal checks on the slice cell, bound to every
// instance of lut_slice_cell.
module lut_slice_cell_chk #(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_mode,
    input logic              cfg_latch,
    input logic              cfg_clk_inv,
    input logic              cfg_ce_inv,
    input logic              cfg_sr_async,
    input logic              cfg_sr_val,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_en,
    input logic              din,
    input logic              op_b,
    input logic              cin,
    input logic              ce,
    input logic              sr,
    input logic              f_out,
    input logic              sum_out,
    input logic              cout,
    input logic              q_out,
    input logic [DEPTH-1:0]  mem_bits
);
    // R1: function mode never alters the table.
    assert_func_table_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd0 || cfg_mode == 2'd3) |=> $stable(mem_bits));

    // R2: an enabled memory write lands at the write address.
    assert_ram_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd1 && wr_en) |=> mem_bits[$past(wr_addr)] == $past(din));

    // R4: an enabled shift puts the serial input in bit 0.
    assert_shift_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd2 && wr_en) |=> mem_bits[0] == $past(din));

    // R5: propagate passes carry in through and sum equals carry in otherwise.
    assert_carry_prop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        f_out |-> (cout == cin));
    assert_carry_gen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !f_out |-> (cout == op_b && sum_out == cin));

    // R7: a disabled flip-flop holds across a rising edge.
    assert_ff_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_latch && !cfg_clk_inv && !sr && ((ce ^ cfg_ce_inv) == 1'b0))
        |=> (sr || !$stable({cfg_latch, cfg_clk_inv, cfg_ce_inv}) || $stable(q_out)));

    // R9: an asynchronous set/reset is already in force at the clock edge.
    assert_async_sr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sr && cfg_sr_async) |-> (q_out == cfg_sr_val));
endmodule

bind lut_slice_cell lut_slice_cell_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_mode     (cfg_mode),
    .cfg_latch    (cfg_latch),
    .cfg_clk_inv  (cfg_clk_inv),
    .cfg_ce_inv   (cfg_ce_inv),
    .cfg_sr_async (cfg_sr_async),
    .cfg_sr_val   (cfg_sr_val),
    .wr_addr      (wr_addr),
    .wr_en        (wr_en),
    .din          (din),
    .op_b         (op_b),
    .cin          (cin),
    .ce           (ce),
    .sr           (sr),
    .f_out        (f_out),
    .sum_out      (sum_out),
    .cout         (cout),
    .q_out        (q_out),
    .mem_bits     (mem_bits)
);

// File: tb/lut_slice_cell_tb.sv
// Directed bench for lut_slice_cell: one task per scenario.
module lut_slice_cell_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic [15:0] cfg_table = 16'h0000;
    logic        cfg_init = 1'b0;
    logic        cfg_latch = 1'b0;
    logic        cfg_clk_inv = 1'b0;
    logic        cfg_ce_inv = 1'b0;
    logic        cfg_sr_async = 1'b0;
    logic        cfg_sr_val = 1'b0;
    logic        cfg_dsel = 1'b0;
    logic [3:0]  rd_addr = 4'd0;
    logic [3:0]  wr_addr = 4'd0;
    logic        wr_en = 1'b0;
    logic        din = 1'b0;
    logic        op_b = 1'b0;
    logic        cin = 1'b0;
    logic        ce = 1'b0;
    logic        sr = 1'b0;
    logic        f_out, sum_out, cout, q_out;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lut_slice_cell u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_table(cfg_table),
        .cfg_init(cfg_init), .cfg_latch(cfg_latch), .cfg_clk_inv(cfg_clk_inv),
        .cfg_ce_inv(cfg_ce_inv), .cfg_sr_async(cfg_sr_async),
        .cfg_sr_val(cfg_sr_val), .cfg_dsel(cfg_dsel), .rd_addr(rd_addr),
        .wr_addr(wr_addr), .wr_en(wr_en), .din(din), .op_b(op_b), .cin(cin),
        .ce(ce), .sr(sr), .f_out(f_out), .sum_out(sum_out), .cout(cout),
        .q_out(q_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reset_dut(input logic [15:0] tbl, input logic init);
        @(negedge clk);
        rst_n = 1'b0; cfg_table = tbl; cfg_init = init; cfg_mode = 2'd0;
        cfg_latch = 1'b0; cfg_clk_inv = 1'b0; cfg_ce_inv = 1'b0;
        cfg_sr_async = 1'b0; cfg_dsel = 1'b0; wr_en = 1'b0; ce = 1'b0; sr = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        reset_dut(16'hA5C3, 1'b1);
        rd_addr = 4'd0; #1;
        chk("R10 init value one", q_out, 1);
        chk("R10 table loaded", f_out, 1);
        reset_dut(16'hA5C3, 1'b0);
        #1 chk("R10 init value zero", q_out, 0);
    endtask

    task automatic t_func();
        logic [15:0] tbl = 16'hA5C3;
        reset_dut(tbl, 1'b0);
        for (int a = 0; a < 16; a++) begin
            rd_addr = 4'(a); #1;
            chk("R1 table lookup", f_out, tbl[a]);
        end
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd0; din = ~tbl[0]; cfg_mode = 2'd3;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; cfg_mode = 2'd0; rd_addr = 4'd0; #1;
        chk("R1 write ignored", f_out, tbl[0]);
    endtask

    task automatic t_ram();
        reset_dut(16'h0000, 1'b0);
        @(negedge clk);
        cfg_mode = 2'd1; wr_addr = 4'd5; din = 1'b1; wr_en = 1'b1; rd_addr = 4'd5; #1;
        chk("R3 old data before edge", f_out, 0);
        @(posedge clk); #1;
        chk("R3 new data after edge", f_out, 1);
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 4'd7;
        @(posedge clk);
        @(negedge clk);
        rd_addr = 4'd7; #1;
        chk("R2 disabled write", f_out, 0);
        wr_addr = 4'd9; wr_en = 1'b1; rd_addr = 4'd5;
        @(posedge clk); #1;
        chk("R2 other address kept", f_out, 1);
        @(negedge clk);
        wr_en = 1'b0; rd_addr = 4'd9; #1;
        chk("R2 separate write address", f_out, 1);
    endtask

    task automatic t_shift();
        logic [15:0] pat = 16'hB38D;
        reset_dut(16'h0000, 1'b0);
        @(negedge clk);
        cfg_mode = 2'd2;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            wr_en = 1'b1; din = pat[i];
            @(posedge clk);
            if (i == 7) begin
                @(negedge clk);
                wr_en = 1'b0; din = ~pat[i];
                @(posedge clk);
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
        for (int n = 0; n < 16; n++) begin
            rd_addr = 4'(n); #1;
            chk("R4 shift tap", f_out, pat[15-n]);
        end
    endtask

    task automatic t_carry();
        reset_dut(16'h6666, 1'b0);
        for (int v = 0; v < 16; v++) begin
            logic f;
            rd_addr = {2'b00, 2'(v)}; op_b = v[2]; cin = v[3]; #1;
            f = v[0] ^ v[1];
            chk("R5 sum", sum_out, f ^ v[3]);
            chk("R5 carry out", cout, f ? v[3] : v[2]);
        end
    endtask

    task automatic t_ff();
        reset_dut(16'h00FF, 1'b0);
        @(negedge clk);
        rd_addr = 4'd0; ce = 1'b1; #1;
        chk("R6 unregistered output", f_out, 1);
        chk("R6 registered not yet", q_out, 0);
        @(posedge clk); #1;
        chk("R6 registered capture", q_out, 1);
        @(negedge clk);
        rd_addr = 4'd8; ce = 1'b0;
        @(posedge clk); #1;
        chk("R7 enable low holds", q_out, 1);
        @(negedge clk);
        cfg_ce_inv = 1'b1;
        @(posedge clk); #1;
        chk("R7 inverted enable captures", q_out, 0);
        @(negedge clk);
        cfg_dsel = 1'b1; cin = 1'b1;
        @(posedge clk); #1;
        chk("R6 sum registered", q_out, 1);
        @(negedge clk);
        cfg_dsel = 1'b0; cin = 1'b0; cfg_ce_inv = 1'b0; ce = 1'b1;
    endtask

    task automatic t_clkinv();
        reset_dut(16'h00FF, 1'b0);
        @(posedge clk); #2;
        cfg_clk_inv = 1'b1; ce = 1'b1; rd_addr = 4'd8;
        @(negedge clk); #1;
        chk("R7 falling capture zero", q_out, 0);
        @(posedge clk); #2;
        rd_addr = 4'd0; #1;
        chk("R7 no rising capture", q_out, 0);
        @(negedge clk); #1;
        chk("R7 falling capture one", q_out, 1);
        ce = 1'b0; cfg_clk_inv = 1'b0;
    endtask

    task automatic t_latch();
        reset_dut(16'h00FF, 1'b0);
        @(negedge clk);
        cfg_latch = 1'b1; ce = 1'b1; rd_addr = 4'd8;
        @(posedge clk); #1;
        chk("R8 open phase loads", q_out, 0);
        #2 rd_addr = 4'd0; #1;
        chk("R8 transparent while high", q_out, 1);
        @(negedge clk); #1;
        rd_addr = 4'd8; #1;
        chk("R8 holds while low", q_out, 1);
        @(negedge clk);
        cfg_latch = 1'b0; ce = 1'b0;
    endtask

    task automatic t_sr();
        reset_dut(16'h00FF, 1'b0);
        @(negedge clk);
        rd_addr = 4'd0; ce = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sr = 1'b1; cfg_sr_val = 1'b0; cfg_sr_async = 1'b0; #1;
        chk("R9 sync waits for edge", q_out, 1);
        @(posedge clk); #1;
        chk("R9 sync reset over enable", q_out, 0);
        @(negedge clk);
        sr = 1'b0; ce = 1'b0; cfg_sr_val = 1'b1; cfg_sr_async = 1'b1;
        #1 sr = 1'b1; #1;
        chk("R9 async set without edge", q_out, 1);
        @(negedge clk);
        sr = 1'b0; cfg_sr_async = 1'b0; #1;
        chk("R9 value kept after release", q_out, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_func();
        t_ram();
        t_shift();
        t_carry();
        t_ff();
        t_clkinv();
        t_latch();
        t_sr();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule